// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block sequences and times a dual-slope integrating analog-to-digital converter. It drives three mutually exclusive switch selects for an external integrator: clamp-to-zero, connect the unknown input, and connect the reference of opposite polarity. It runs a fixed-length zeroing phase, then integrates the unknown input for a fixed number of clocks. It then discharges with the reference while counting clocks, until the zero-crossing comparator reports that the integrator has returned to its baseline. The count is the conversion result. It is presented in binary together with a one-cycle valid strobe.

While `run` is high, conversions follow one another back to back. A single all-switches-open cycle separates each pair of phases so that two switches never conduct together. If the comparator never reports a crossing, the de-integration is cut off after twice the integration length and the result is flagged as over range. The comparator input is asynchronous. It is brought into the clock domain by a two-flop synchronizer, and the first rising edge of the synchronized signal ends the count.

The states are IDLE, ZERO (auto-zero), GAP_ZI (dead cycle), INTEG (input integrate), GAP_ID (dead cycle), DEINT (reference de-integrate) and GAP_DZ (dead cycle). The transitions are:
- IDLE→ZERO when `run` is high.
- ZERO→GAP_ZI after AZ_CYC cycles.
- GAP_ZI→INTEG after one cycle.
- INTEG→GAP_ID after INT_CYC cycles.
- GAP_ID→DEINT after one cycle.
- DEINT→GAP_DZ on a synchronized comparator rise or on timeout.
- GAP_DZ→ZERO if `run` is high, otherwise GAP_DZ→IDLE.

Top module: `dslope_seq`

## Requirements
- R1: After reset the block is in IDLE. All three switch selects are 0, and `result`, `result_vld` and `overrange` are 0.
- R2: At most one switch select is high in any cycle. `sw_zero` stays high for exactly AZ_CYC consecutive cycles in each conversion.
- R3: `sw_input` stays high for exactly INT_CYC consecutive cycles in each conversion.
- R4: The phases run in the order zero, input, reference, and then zero again. Exactly one cycle with all switch selects low separates each pair of phases.
- R5: `sw_ref` stays high until the first rising edge of the synchronized comparator. The synchronizer has two flops and is followed by an edge flop. `result` equals the number of DEINT cycles that come before the cycle in which the synchronized rise is seen. In the next cycle `result_vld` is high for exactly one cycle, together with the new `result`.
- R6: If no rise is seen within TIMEOUT = 2*INT_CYC DEINT cycles, `result` is TIMEOUT and `overrange` is 1. A rise seen in the last allowed cycle still counts as a normal result. `overrange` is 0 with every normal result.
- R7: Comparator edges outside DEINT have no effect on the result.
- R8: While `run` is high, conversions repeat with no idle gap. Consecutive `result_vld` pulses are AZ_CYC+INT_CYC+result+4 cycles apart.
- R9: When `run` falls, the current conversion completes and the block returns to IDLE with all switches open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables continuous conversions |
| cmp_in | input | 1 | Asynchronous comparator: high when the integrator is at or below zero |
| sw_zero | output | 1 | Auto-zero switch select |
| sw_input | output | 1 | Unknown-input switch select |
| sw_ref | output | 1 | Reference switch select |
| result | output | $clog2(2*INT_CYC+1) | De-integrate count |
| result_vld | output | 1 | One-cycle strobe with each new result |
| overrange | output | 1 | Set with a timed-out result |

## Verification
The embedded assertions check on every cycle that the switch selects are mutually exclusive, and that a falling switch is followed by an all-open cycle. They also check that the integrate phase has its fixed length, that the valid strobe lasts one cycle, that results stay in bounds, and that timeouts report the limit value. Only the bench scenarios, driving a behavioural integrator model, can show that the count matches the charge balance for several input levels. The same holds for the boundary between the last valid count and overrange, for glitches on the comparator during integration being ignored, for the back-to-back conversion period, and for the orderly stop when `run` falls.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ZERO   = 3'd1,
        ST_GAP_ZI = 3'd2,
        ST_INTEG  = 3'd3,
        ST_GAP_ID = 3'd4,
        ST_DEINT  = 3'd5,
        ST_GAP_DZ = 3'd6
    } phase_t;
endpackage

// File: rtl/dslope_sync.sv
// Multi-flop synchronizer with a rising-edge detector behind it.
module dslope_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], async_in};
    end

    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/dslope_timer.sv
// Phase cycle counter: cleared on every phase change.
module dslope_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dslope_result.sv
// Result register with overrange flag and one-cycle valid strobe.
module dslope_result #(
    parameter int W       = 8,
    parameter int TIMEOUT = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         load_ovr,
    output logic [W-1:0] result,
    output logic         overrange,
    output logic         result_vld
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result     <= '0;
            overrange  <= 1'b0;
            result_vld <= 1'b0;
        end else begin
            result_vld <= load;
            if (load) begin
                result    <= load_val;
                overrange <= load_ovr;
            end
        end
    end

    a_r5_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld |=> !result_vld);
    a_r6_ovr_value: assert property (@(posedge clk) disable iff (!rst_n)
        (result_vld && overrange) |-> (result == W'(TIMEOUT)));
    a_r5_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld |-> (result <= W'(TIMEOUT)));
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
    import dslope_pkg::*;
#(
    parameter int INT_CYC = 64,
    parameter int AZ_CYC  = 16,
    parameter int SYNC_STAGES = 2,
    localparam int TIMEOUT = 2 * INT_CYC,
    localparam int RES_W   = $clog2(TIMEOUT + 1),
    localparam int CNT_W   = $clog2(TIMEOUT + AZ_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cmp_in,
    output logic             sw_zero,
    output logic             sw_input,
    output logic             sw_ref,
    output logic [RES_W-1:0] result,
    output logic             result_vld,
    output logic             overrange
);
    phase_t             state, state_nx;
    logic [CNT_W-1:0]   cnt;
    logic               cmp_rise;
    logic               ld;
    logic               ld_ovr;
    logic [RES_W-1:0]   ld_val;

    dslope_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cmp_in), .rise(cmp_rise)
    );

    dslope_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(state_nx != state), .cnt(cnt)
    );

    dslope_result #(.W(RES_W), .TIMEOUT(TIMEOUT)) u_res (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val),
        .load_ovr(ld_ovr), .result(result), .overrange(overrange),
        .result_vld(result_vld)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state and result capture
    always_comb begin
        state_nx = state;
        ld       = 1'b0;
        ld_ovr   = 1'b0;
        ld_val   = RES_W'(cnt);
        unique case (state)
            ST_IDLE:   if (run) state_nx = ST_ZERO;
            ST_ZERO:   if (cnt == CNT_W'(AZ_CYC - 1)) state_nx = ST_GAP_ZI;
            ST_GAP_ZI: state_nx = ST_INTEG;
            ST_INTEG:  if (cnt == CNT_W'(INT_CYC - 1)) state_nx = ST_GAP_ID;
            ST_GAP_ID: state_nx = ST_DEINT;
            ST_DEINT: begin
                if (cmp_rise) begin
                    state_nx = ST_GAP_DZ;
                    ld       = 1'b1;
                end else if (cnt == CNT_W'(TIMEOUT - 1)) begin
                    state_nx = ST_GAP_DZ;
                    ld       = 1'b1;
                    ld_ovr   = 1'b1;
                    ld_val   = RES_W'(TIMEOUT);
                end
            end
            ST_GAP_DZ: state_nx = run ? ST_ZERO : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // switch decode
    always_comb begin
        sw_zero  = 1'b0;
        sw_input = 1'b0;
        sw_ref   = 1'b0;
        unique case (state)
            ST_ZERO:  sw_zero  = 1'b1;
            ST_INTEG: sw_input = 1'b1;
            ST_DEINT: sw_ref   = 1'b1;
            default:  ;
        endcase
    end

    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sw_zero, sw_input, sw_ref}));
    a_r4_gap_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_zero) |-> !(sw_input || sw_ref));
    a_r4_gap_after_input: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_input) |-> !(sw_zero || sw_ref));
    a_r4_gap_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_ref) |-> !(sw_zero || sw_input));
    a_r3_int_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_input) |-> ($past(cnt) == CNT_W'(INT_CYC - 1)));
    a_r5_load_in_ref: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_vld) |-> $past(sw_ref));
endmodule

// File: tb/tb_dslope_seq.sv
module tb_dslope_seq;
    localparam int INT_CYC = 16;
    localparam int AZ_CYC  = 4;
    localparam int TIMEOUT = 2 * INT_CYC;
    localparam int RES_W   = $clog2(TIMEOUT + 1);
    localparam int VREF    = 16;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic noise = 1'b0;
    logic cmp_in;
    logic sw_zero, sw_input, sw_ref, result_vld, overrange;
    logic [RES_W-1:0] result;

    int vin = 5;
    int vint = 0;
    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    dslope_seq #(.INT_CYC(INT_CYC), .AZ_CYC(AZ_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .run(run), .cmp_in(cmp_in),
        .sw_zero(sw_zero), .sw_input(sw_input), .sw_ref(sw_ref),
        .result(result), .result_vld(result_vld), .overrange(overrange)
    );

    // behavioural integrator, updated away from the active edge
    always @(negedge clk) begin
        if (sw_zero)       vint <= 0;
        else if (sw_input) vint <= vint + vin;
        else if (sw_ref)   vint <= vint - VREF;
    end
    assign cmp_in = (vint <= 0) ^ noise;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WD_LIMIT && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual cycles=%0d expected < %0d", cycles, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_res(input int v);
        int k = (INT_CYC * v + VREF - 1) / VREF;
        return (k + 1 <= TIMEOUT - 1) ? k + 1 : TIMEOUT;
    endfunction

    task automatic wait_vld();
        @(negedge clk);
        while (!result_vld) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 switches", {sw_zero, sw_input, sw_ref}, 0);
        chk("R1 result", result, 0);
        chk("R1 vld", result_vld, 0);
        chk("R1 overrange", overrange, 0);
        repeat (5) @(negedge clk);
        chk("R9 idle no switches", {sw_zero, sw_input, sw_ref}, 0);
    endtask

    // one conversion from idle, then stop
    task automatic t_convert(input int v, input string req);
        int e = exp_res(v);
        vin = v;
        run = 1'b1;
        wait_vld();
        run = 1'b0;
        chk({req, " result"}, result, e);
        chk({req, " overrange"}, overrange, (e == TIMEOUT) ? 1 : 0);
        @(negedge clk);
        chk("R5 vld one cycle", result_vld, 0);
        repeat (4) @(negedge clk);
        chk("R9 back to idle", {sw_zero, sw_input, sw_ref}, 0);
    endtask

    // phase lengths and gaps over one conversion
    task automatic t_phases();
        int n;
        vin = 5;
        run = 1'b1;
        @(negedge clk);
        while (!sw_zero) @(negedge clk);
        n = 0;
        while (sw_zero) begin n++; @(negedge clk); end
        chk("R2 zero length", n, AZ_CYC);
        chk("R4 gap after zero", {sw_zero, sw_input, sw_ref}, 0);
        @(negedge clk);
        n = 0;
        while (sw_input) begin n++; @(negedge clk); end
        chk("R3 integrate length", n, INT_CYC);
        chk("R4 gap after input", {sw_zero, sw_input, sw_ref}, 0);
        @(negedge clk);
        n = 0;
        while (sw_ref) begin
            n++;
            if (sw_zero || sw_input) chk("R2 exclusive", 1, 0);
            @(negedge clk);
        end
        chk("R5 deint length", n, exp_res(5) + 1);
        chk("R4 gap after ref", {sw_zero, sw_input, sw_ref}, 0);
        @(negedge clk);
        chk("R8 zero follows", sw_zero, 1);
    endtask

    // period between back-to-back results
    task automatic t_period();
        int n = 0;
        wait_vld();
        @(negedge clk);
        while (!result_vld) begin n++; @(negedge clk); end
        chk("R8 period", n + 1, AZ_CYC + INT_CYC + exp_res(5) + 4);
        chk("R8 repeated result", result, exp_res(5));
        run = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    // comparator glitch during integration must not disturb the count
    task automatic t_glitch();
        vin = 7;
        run = 1'b1;
        @(negedge clk);
        while (!sw_input) @(negedge clk);
        repeat (3) @(negedge clk);
        noise = 1'b1;
        repeat (3) @(negedge clk);
        noise = 1'b0;
        wait_vld();
        run = 1'b0;
        chk("R7 glitch ignored", result, exp_res(7));
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_convert(5, "R5 vin5");
        t_convert(1, "R5 vin1");
        t_convert(16, "R5 vin16");
        t_convert(30, "R6 last valid");
        t_convert(31, "R6 overrange");
        t_convert(3, "R6 cleared");
        t_phases();
        t_period();
        t_glitch();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule